// File: doc/BRIEF.md
# PCI Slot Hotplug Register Bank

This block keeps the hotplug bookkeeping for a bank of PCI slots, by default 32 of them. It holds a present mask, a pending-removal mask and a hotplug-enable mask, and it raises a general-purpose event status bit whenever a slot is hot-inserted or a hot-removal is requested. Firmware reads and writes these through four 32-bit words on a small host I/O port. A sideband event port reports cold-plugs, hot-inserts and hot-remove requests for a slot number.

A strap vector marks slots whose device can never be unplugged. A second vector reports which slots hold a device. Together they stand in for scanning a real bus and for the physical departure of a device. A rebuild request starts a sequencer. It retires every pending removal one slot per clock, then reloads the enable mask from the strap and the present mask from the occupancy vector.

Top module: `hp_slot_bank`

## Requirements
- R1: After `rst_n` is low at a clock edge, the present and pending masks are zero, the enable mask is all ones, `gpe_status` is zero, `busy` is low and `bus_rvalid` is low.
- R2: A read is sampled at a clock edge when `bus_valid` is high and `bus_write` is low. The result appears on `bus_rdata` with `bus_rvalid` high for exactly the following cycle. The offsets are: 0x0 returns present AND enable, 0x4 returns the pending-removal mask, 0x8 returns zero, and 0xC returns the enable mask.
- R3: A cold-plug event (`ev_kind` = 0) sets the slot's present bit and leaves `gpe_status` unchanged.
- R4: A hot-insert event (`ev_kind` = 1) sets the slot's present bit and sets `gpe_status` bit 1.
- R5: A hot-remove event (`ev_kind` = 2) sets the slot's pending bit and sets `gpe_status` bit 1. Kind 3 does nothing.
- R6: A full write to offset 0x8 takes only the lowest set bit of the written value. It clears that slot's pending bit. It also clears the slot's present bit unless `fixed_slots` marks that slot.
- R7: A write of zero to offset 0x8 changes no mask.
- R8: An access whose `bus_be` is not 4'hF reads as zero and changes no state when it is a write.
- R9: A pulse on `gpe_ack` clears `gpe_status` bit 1. An event that sets the bit in the same cycle wins over the clear.
- R10: When `rebuild_req` is sampled high while idle, `busy` rises at the next edge. Each following cycle retires the lowest pending slot, with the same rule as R6. Once nothing is pending, one more cycle sets enable to NOT `fixed_slots` and present to `occupied_slots`, and `busy` falls. With k pending slots, `busy` stays high for k+1 cycles.
- R11: While `busy` is high, and in the cycle that `rebuild_req` is sampled, events and eject writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Host access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset of the word |
| bus_be | input | 4 | Byte enables; only 4'hF is a valid access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_rvalid | output | 1 | Read data valid |
| ev_valid | input | 1 | Slot event strobe |
| ev_kind | input | 2 | 0 cold-plug, 1 hot-insert, 2 hot-remove, 3 none |
| ev_slot | input | 5 | Slot number of the event |
| fixed_slots | input | 32 | Strap: slot cannot be hot-unplugged |
| occupied_slots | input | 32 | Slots holding a device, used by rebuild |
| rebuild_req | input | 1 | Start the removal walk and mask rebuild |
| gpe_ack | input | 1 | Clear the hotplug event status bit |
| gpe_status | output | 8 | Event status; bit 1 is the hotplug event |
| busy | output | 1 | Rebuild sequencer active |

## Verification
The hardest state to reach from the ports is a rebuild that starts with several slots pending, one of them strapped as fixed, while events keep arriving during the walk. The bench first queues three hot-removes with separate events, one of them on a fixed slot. It then pulses the rebuild and counts the cycles in which `busy` is high. It fires a hot-insert in the middle of the walk. Afterwards it reads the masks back through the host port, and it checks that the event status bit did not rise.

// File: rtl/hp_pkg.sv
// Package: shared types and constants of the slot hotplug bank.
// Assumes a host word of 32 bits and byte offsets on a 4-bit address.
package hp_pkg;

    localparam int BUS_W   = 32;
    localparam int ADDR_W  = 4;
    localparam int GPE_W   = 8;
    localparam int GPE_BIT = 1;

    localparam logic [ADDR_W-1:0] OFS_UP    = 4'h0;
    localparam logic [ADDR_W-1:0] OFS_DOWN  = 4'h4;
    localparam logic [ADDR_W-1:0] OFS_EJECT = 4'h8;
    localparam logic [ADDR_W-1:0] OFS_RMV   = 4'hC;

    typedef enum logic [1:0] {
        EV_COLD   = 2'd0,
        EV_INSERT = 2'd1,
        EV_REMOVE = 2'd2,
        EV_NONE   = 2'd3
    } ev_kind_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WALK = 1'b1
    } walk_st_t;

endpackage

// File: rtl/hp_lowest_pick.sv
// Module: isolates the lowest set bit of a vector as a one-hot word.
// Assumes nothing about the input; an all-zero input gives all-zero output.
module hp_lowest_pick #(
    parameter int N = 32
) (
    input  logic [N-1:0] vec,
    output logic [N-1:0] onehot,
    output logic         any
);

    logic [N:0] seen;

    assign seen[0] = 1'b0;

    // Ripple a "lower bit already set" flag and keep the first hit.
    for (genvar i = 0; i < N; i++) begin : g_bit
        assign seen[i+1]  = seen[i] | vec[i];
        assign onehot[i]  = vec[i] & ~seen[i];
    end

    assign any = seen[N];

endmodule

// File: rtl/hp_bus_decode.sv
// Module: decodes host accesses into register selects and the eject strobe.
// Assumes one access per cycle; only full-word byte enables are honoured.
module hp_bus_decode
    import hp_pkg::*;
#(
    parameter int NSLOT = 32
) (
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [3:0]        bus_be,
    input  logic [BUS_W-1:0]  bus_wdata,
    input  logic              accept,
    output logic              rd_en,
    output logic              rd_full,
    output logic [3:0]        rd_sel,
    output logic              eject_wr,
    output logic [NSLOT-1:0]  eject_vec
);

    logic full;

    // Classify the access: full-word and read or eject write.
    always_comb begin
        full     = (bus_be == 4'hF);
        rd_en    = bus_valid && !bus_write;
        rd_full  = full;
        rd_sel   = {bus_addr == OFS_RMV, bus_addr == OFS_EJECT,
                    bus_addr == OFS_DOWN, bus_addr == OFS_UP};
        eject_wr = bus_valid && bus_write && full && accept &&
                   (bus_addr == OFS_EJECT);
    end

    // Take the slot-wide part of the written word as the eject request.
    for (genvar i = 0; i < NSLOT; i++) begin : g_ej
        assign eject_vec[i] = bus_wdata[i];
    end

endmodule

// File: rtl/hp_read_port.sv
// Module: registers the host read data for the four hotplug words.
// Assumes NSLOT <= BUS_W; upper bits of narrower masks read as zero.
module hp_read_port
    import hp_pkg::*;
#(
    parameter int NSLOT = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              rd_full,
    input  logic [3:0]        rd_sel,
    input  logic [NSLOT-1:0]  up_mask,
    input  logic [NSLOT-1:0]  down_mask,
    input  logic [NSLOT-1:0]  rmv_mask,
    output logic [BUS_W-1:0]  rdata,
    output logic              rvalid
);

    logic [BUS_W-1:0] up_w, down_w, rmv_w, mux_w;

    // Widen each slot mask to a host word.
    for (genvar i = 0; i < BUS_W; i++) begin : g_ext
        if (i < NSLOT) begin : g_in
            assign up_w[i]   = up_mask[i];
            assign down_w[i] = down_mask[i];
            assign rmv_w[i]  = rmv_mask[i];
        end else begin : g_pad
            assign up_w[i]   = 1'b0;
            assign down_w[i] = 1'b0;
            assign rmv_w[i]  = 1'b0;
        end
    end

    // Select the word for the addressed register; eject reads as zero.
    always_comb begin
        mux_w = '0;
        if (rd_full) begin
            unique case (1'b1)
                rd_sel[0]: mux_w = up_w;
                rd_sel[1]: mux_w = down_w;
                rd_sel[3]: mux_w = rmv_w;
                default:   mux_w = '0;
            endcase
        end
    end

    // Capture read data and its valid flag one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= rd_en;
            rdata  <= rd_en ? mux_w : '0;
        end
    end

endmodule

// File: rtl/hp_slot_state.sv
// Module: holds present, pending and enable masks, the event status bit
// and the rebuild sequencer. Assumes event vectors are one-hot or zero.
module hp_slot_state
    import hp_pkg::*;
#(
    parameter int NSLOT = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             eject_wr,
    input  logic [NSLOT-1:0] eject_vec,
    input  logic [NSLOT-1:0] cold_vec,
    input  logic [NSLOT-1:0] ins_vec,
    input  logic [NSLOT-1:0] rem_vec,
    input  logic             rebuild_req,
    input  logic             gpe_ack,
    input  logic [NSLOT-1:0] fixed_slots,
    input  logic [NSLOT-1:0] occupied_slots,
    output logic [NSLOT-1:0] present_mask,
    output logic [NSLOT-1:0] down_mask,
    output logic [NSLOT-1:0] hpen_mask,
    output logic [GPE_W-1:0] gpe_status,
    output logic             busy
);

    walk_st_t         st_q, st_d;
    logic [NSLOT-1:0] present_d, down_d, hpen_d;
    logic [NSLOT-1:0] pick_src, pick_oh;
    logic             pick_any;
    logic             hot_evt;

    // Walking uses the pending mask; idle uses the eject write value.
    assign pick_src = (st_q == ST_WALK) ? down_mask :
                      (eject_wr ? eject_vec : '0);

    hp_lowest_pick #(.N(NSLOT)) u_pick (
        .vec    (pick_src),
        .onehot (pick_oh),
        .any    (pick_any)
    );

    assign hot_evt = |(ins_vec | rem_vec);
    assign busy    = (st_q == ST_WALK);

    // Next-state of masks and sequencer.
    always_comb begin
        st_d      = st_q;
        present_d = present_mask;
        down_d    = down_mask;
        hpen_d    = hpen_mask;
        if (st_q == ST_IDLE) begin
            if (rebuild_req) begin
                st_d = ST_WALK;
            end else begin
                if (pick_any) begin
                    down_d    = down_d & ~pick_oh;
                    present_d = present_d & ~(pick_oh & ~fixed_slots);
                end
                present_d = present_d | cold_vec | ins_vec;
                down_d    = down_d | rem_vec;
            end
        end else begin
            if (pick_any) begin
                down_d    = down_mask & ~pick_oh;
                present_d = present_mask & ~(pick_oh & ~fixed_slots);
            end else begin
                hpen_d    = ~fixed_slots;
                present_d = occupied_slots;
                st_d      = ST_IDLE;
            end
        end
    end

    // Register masks and sequencer state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q         <= ST_IDLE;
            present_mask <= '0;
            down_mask    <= '0;
            hpen_mask    <= '1;
        end else begin
            st_q         <= st_d;
            present_mask <= present_d;
            down_mask    <= down_d;
            hpen_mask    <= hpen_d;
        end
    end

    // Hold the hotplug event status bit; a new event wins over the clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gpe_status <= '0;
        end else if (hot_evt) begin
            gpe_status[GPE_BIT] <= 1'b1;
        end else if (gpe_ack) begin
            gpe_status[GPE_BIT] <= 1'b0;
        end
    end

endmodule

// File: rtl/hp_slot_bank.sv
// Module: top of the slot hotplug bank; decodes sideband events into slot
// vectors and joins host decode, state and read port.
// Assumes ev_slot values at or above NSLOT are dropped.
module hp_slot_bank
    import hp_pkg::*;
#(
    parameter int NSLOT = 32,
    localparam int SW   = $clog2(NSLOT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [3:0]        bus_addr,
    input  logic [3:0]        bus_be,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_rvalid,
    input  logic              ev_valid,
    input  logic [1:0]        ev_kind,
    input  logic [SW-1:0]     ev_slot,
    input  logic [NSLOT-1:0]  fixed_slots,
    input  logic [NSLOT-1:0]  occupied_slots,
    input  logic              rebuild_req,
    input  logic              gpe_ack,
    output logic [7:0]        gpe_status,
    output logic              busy
);

    logic             accept;
    logic             rd_en, rd_full, eject_wr;
    logic [3:0]       rd_sel;
    logic [NSLOT-1:0] eject_vec, cold_vec, ins_vec, rem_vec;
    logic [NSLOT-1:0] present_mask, down_mask, hpen_mask;
    ev_kind_t         kind;

    assign accept = !busy && !rebuild_req;
    assign kind   = ev_kind_t'(ev_kind);

    // Expand an accepted event into per-kind one-hot slot vectors.
    for (genvar i = 0; i < NSLOT; i++) begin : g_ev
        logic hit;
        assign hit         = ev_valid && accept && (ev_slot == SW'(i));
        assign cold_vec[i] = hit && (kind == EV_COLD);
        assign ins_vec[i]  = hit && (kind == EV_INSERT);
        assign rem_vec[i]  = hit && (kind == EV_REMOVE);
    end

    hp_bus_decode #(.NSLOT(NSLOT)) u_dec (
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_be    (bus_be),
        .bus_wdata (bus_wdata),
        .accept    (accept),
        .rd_en     (rd_en),
        .rd_full   (rd_full),
        .rd_sel    (rd_sel),
        .eject_wr  (eject_wr),
        .eject_vec (eject_vec)
    );

    hp_slot_state #(.NSLOT(NSLOT)) u_state (
        .clk            (clk),
        .rst_n          (rst_n),
        .eject_wr       (eject_wr),
        .eject_vec      (eject_vec),
        .cold_vec       (cold_vec),
        .ins_vec        (ins_vec),
        .rem_vec        (rem_vec),
        .rebuild_req    (rebuild_req),
        .gpe_ack        (gpe_ack),
        .fixed_slots    (fixed_slots),
        .occupied_slots (occupied_slots),
        .present_mask   (present_mask),
        .down_mask      (down_mask),
        .hpen_mask      (hpen_mask),
        .gpe_status     (gpe_status),
        .busy           (busy)
    );

    hp_read_port #(.NSLOT(NSLOT)) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en     (rd_en),
        .rd_full   (rd_full),
        .rd_sel    (rd_sel),
        .up_mask   (present_mask & hpen_mask),
        .down_mask (down_mask),
        .rmv_mask  (hpen_mask),
        .rdata     (bus_rdata),
        .rvalid    (bus_rvalid)
    );

endmodule

// File: rtl/hp_slot_bank_chk.sv
// Module: property checker for the slot hotplug bank, bound to the top.
// Assumes it sees the top ports and the three internal masks.
module hp_slot_bank_chk #(
    parameter int NSLOT = 32,
    localparam int SW   = $clog2(NSLOT)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_valid,
    input logic             bus_write,
    input logic [3:0]       bus_addr,
    input logic [3:0]       bus_be,
    input logic [31:0]      bus_wdata,
    input logic [31:0]      bus_rdata,
    input logic             bus_rvalid,
    input logic             ev_valid,
    input logic [1:0]       ev_kind,
    input logic [SW-1:0]    ev_slot,
    input logic [NSLOT-1:0] fixed_slots,
    input logic             rebuild_req,
    input logic [7:0]       gpe_status,
    input logic             busy,
    input logic [NSLOT-1:0] present_mask,
    input logic [NSLOT-1:0] down_mask,
    input logic [NSLOT-1:0] hpen_mask
);

    logic acc;
    assign acc = rst_n && !busy && !rebuild_req;

    // R4
    insert_raises_gpe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc && ev_valid && ev_kind == 2'd1 |=> gpe_status[1] && present_mask[$past(ev_slot)]);

    // R5
    remove_sets_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc && ev_valid && ev_kind == 2'd2 |=> gpe_status[1] && down_mask[$past(ev_slot)]);

    // R8
    partial_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc && bus_valid && bus_write && bus_be != 4'hF && !ev_valid
        |=> $stable(down_mask) && $stable(present_mask));

    // R8
    partial_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && !bus_write && bus_be != 4'hF |=> bus_rvalid && bus_rdata == 32'd0);

    // R7
    eject_zero_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc && bus_valid && bus_write && bus_be == 4'hF && bus_addr == 4'h8 &&
        bus_wdata == 32'd0 && !ev_valid |=> $stable(down_mask) && $stable(present_mask));

    // R10
    walk_one_per_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && down_mask != '0 |=> $countones(down_mask) == $countones($past(down_mask)) - 1);

    // R10
    rebuild_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> down_mask == '0 && hpen_mask == ~$past(fixed_slots));

    // R11
    busy_no_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !$rose(gpe_status[1]));

endmodule

bind hp_slot_bank hp_slot_bank_chk #(.NSLOT(NSLOT)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_valid    (bus_valid),
    .bus_write    (bus_write),
    .bus_addr     (bus_addr),
    .bus_be       (bus_be),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .bus_rvalid   (bus_rvalid),
    .ev_valid     (ev_valid),
    .ev_kind      (ev_kind),
    .ev_slot      (ev_slot),
    .fixed_slots  (fixed_slots),
    .rebuild_req  (rebuild_req),
    .gpe_status   (gpe_status),
    .busy         (busy),
    .present_mask (present_mask),
    .down_mask    (down_mask),
    .hpen_mask    (hpen_mask)
);

// File: tb/hp_slot_bank_bench.sv
// Bench: directed scenarios for the slot hotplug bank, one task each.
module hp_slot_bank_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0, bus_write = 1'b0;
    logic [3:0]  bus_addr = '0, bus_be = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic        bus_rvalid;
    logic        ev_valid = 1'b0;
    logic [1:0]  ev_kind = 2'd3;
    logic [4:0]  ev_slot = '0;
    logic [31:0] fixed_slots = 32'h0000_0008;
    logic [31:0] occupied_slots = 32'h0000_1008;
    logic        rebuild_req = 1'b0, gpe_ack = 1'b0;
    logic [7:0]  gpe_status;
    logic        busy;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    hp_slot_bank u_hp_slot_bank (
        .clk(clk), .rst_n(rst_n),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .ev_valid(ev_valid), .ev_kind(ev_kind),
        .ev_slot(ev_slot), .fixed_slots(fixed_slots),
        .occupied_slots(occupied_slots), .rebuild_req(rebuild_req),
        .gpe_ack(gpe_ack), .gpe_status(gpe_status), .busy(busy)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [3:0] a, input logic [3:0] be, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a; bus_be = be;
        @(negedge clk);
        bus_valid = 1'b0;
        d = bus_rvalid ? bus_rdata : 32'hDEAD_BEEF;
    endtask

    task automatic wr(input logic [3:0] a, input logic [3:0] be, input logic [31:0] v);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_be = be; bus_wdata = v;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic evt(input logic [1:0] k, input logic [4:0] s);
        @(negedge clk);
        ev_valid = 1'b1; ev_kind = k; ev_slot = s;
        @(negedge clk);
        ev_valid = 1'b0; ev_kind = 2'd3;
    endtask

    task automatic ack_gpe();
        @(negedge clk);
        gpe_ack = 1'b1;
        @(negedge clk);
        gpe_ack = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R1 gpe", {24'd0, gpe_status}, 32'd0);
        check("R1 busy", {31'd0, busy}, 32'd0);
        rd(4'h0, 4'hF, d); check("R1 up", d, 32'd0);
        rd(4'h4, 4'hF, d); check("R1 down", d, 32'd0);
        rd(4'hC, 4'hF, d); check("R1 rmv", d, 32'hFFFF_FFFF);
    endtask

    task automatic t_cold();
        logic [31:0] d;
        evt(2'd0, 5'd3);
        check("R3 gpe quiet", {24'd0, gpe_status}, 32'd0);
        rd(4'h0, 4'hF, d); check("R3 up", d, 32'h0000_0008);
    endtask

    task automatic t_insert();
        logic [31:0] d;
        evt(2'd1, 5'd5);
        check("R4 gpe", {31'd0, gpe_status[1]}, 32'd1);
        rd(4'h0, 4'hF, d); check("R4 up", d, 32'h0000_0028);
        ack_gpe();
        check("R9 cleared", {24'd0, gpe_status}, 32'd0);
    endtask

    task automatic t_remove();
        logic [31:0] d;
        evt(2'd2, 5'd5);
        check("R5 gpe", {31'd0, gpe_status[1]}, 32'd1);
        rd(4'h4, 4'hF, d); check("R5 down", d, 32'h0000_0020);
        evt(2'd3, 5'd9);
        rd(4'h4, 4'hF, d); check("R5 kind3 none", d, 32'h0000_0020);
        // ack and a new event in the same cycle: event wins
        @(negedge clk);
        gpe_ack = 1'b1; ev_valid = 1'b1; ev_kind = 2'd1; ev_slot = 5'd6;
        @(negedge clk);
        gpe_ack = 1'b0; ev_valid = 1'b0; ev_kind = 2'd3;
        check("R9 set wins", {31'd0, gpe_status[1]}, 32'd1);
        ack_gpe();
    endtask

    task automatic t_eject();
        logic [31:0] d;
        evt(2'd2, 5'd8);
        wr(4'h8, 4'hF, 32'h0000_0120);
        rd(4'h4, 4'hF, d); check("R6 lowest only", d, 32'h0000_0100);
        rd(4'h0, 4'hF, d); check("R6 present", d, 32'h0000_0048);
        wr(4'h8, 4'hF, 32'h0000_0008);
        rd(4'h0, 4'hF, d); check("R6 fixed kept", d, 32'h0000_0048);
        wr(4'h8, 4'hF, 32'd0);
        rd(4'h4, 4'hF, d); check("R7 down", d, 32'h0000_0100);
        rd(4'h0, 4'hF, d); check("R7 up", d, 32'h0000_0048);
        rd(4'h8, 4'hF, d); check("R2 eject reads 0", d, 32'd0);
    endtask

    task automatic t_partial();
        logic [31:0] d;
        wr(4'h8, 4'h3, 32'h0000_0100);
        rd(4'h4, 4'hF, d); check("R8 write ignored", d, 32'h0000_0100);
        rd(4'h0, 4'h1, d); check("R8 partial read", d, 32'd0);
    endtask

    task automatic t_rebuild();
        logic [31:0] d;
        int busy_cycles = 0;
        evt(2'd2, 5'd2);
        evt(2'd2, 5'd3);
        ack_gpe();
        rd(4'h4, 4'hF, d); check("R10 pending", d, 32'h0000_010C);
        @(negedge clk);
        rebuild_req = 1'b1;
        @(negedge clk);
        rebuild_req = 1'b0;
        while (busy && busy_cycles < 50) begin
            if (busy_cycles == 1) begin
                ev_valid = 1'b1; ev_kind = 2'd1; ev_slot = 5'd20;
            end else begin
                ev_valid = 1'b0; ev_kind = 2'd3;
            end
            busy_cycles++;
            @(negedge clk);
        end
        ev_valid = 1'b0; ev_kind = 2'd3;
        check("R10 busy cycles", busy_cycles, 32'd4);
        check("R11 no gpe", {24'd0, gpe_status}, 32'd0);
        rd(4'h4, 4'hF, d); check("R10 down", d, 32'd0);
        rd(4'hC, 4'hF, d); check("R10 rmv", d, 32'hFFFF_FFF7);
        rd(4'h0, 4'hF, d); check("R11 up", d, 32'h0000_1000);
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 rvalid idle", {31'd0, bus_rvalid}, 32'd0);
        t_reset();
        t_cold();
        t_insert();
        t_remove();
        t_eject();
        t_partial();
        t_rebuild();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule